// File: doc/BRIEF.md
# Pipelined Stable Key Sorter

This block orders eight unsigned keys, each carrying an index tag. It is a
transposition network of compare-exchange cells. The layers alternate
between two pairing patterns. Adjacent lanes are compared and exchanged
whenever the lower lane holds the larger key. Only the key takes part in the
comparison, and the tag moves with its key through every exchange. A typical
use is to sort large records through their (key, index) pairs.

Each comparator layer ends in a register. A fresh set of eight pairs can
therefore enter on every clock. Up to eight independent sets are in flight
at once, one per layer. A valid bit moves down the pipeline in step with the
data. Cycles without valid input produce bubbles at the output in the same
positions.

Top module: `sortnet_top`

## Requirements
- R1: Every compare-exchange cell places the smaller key on its lower-numbered lane and the larger key on its higher-numbered lane.
- R2: When out_valid is high, the output keys do not decrease from lane 0 to lane 7. Lane i occupies bits [i*KEY_W +: KEY_W] of in_key and out_key.
- R3: out_valid is high in a cycle exactly when in_valid was high eight cycles earlier. That set is then present on the outputs in that cycle.
- R4: Each output index is the index that entered paired with that output key. Lane i occupies bits [i*IDX_W +: IDX_W] of in_idx and out_idx.
- R5: One set is accepted on every cycle in which in_valid is high, with no gaps required between sets. Back-to-back sets leave the block in consecutive cycles, in the order they entered.
- R6: While rst_n is low, and afterwards until a valid set has crossed all eight layers, out_valid is low.
- R7: Two elements with equal keys leave in the same relative order in which they entered.
- R8: Keys compare as unsigned numbers, so a key with its top bit set sorts above every key with that bit clear.
- R9: Inputs presented while in_valid is low produce no valid output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the valid chain |
| in_valid | input | 1 | Marks in_key and in_idx as a set to sort |
| in_key | input | N_ELEM*KEY_W | Eight unsigned keys, lane i at [i*KEY_W +: KEY_W] |
| in_idx | input | N_ELEM*IDX_W | Index tag per lane, lane i at [i*IDX_W +: IDX_W] |
| out_valid | output | 1 | Marks the sorted set on the outputs |
| out_key | output | N_ELEM*KEY_W | Keys in ascending order from lane 0 |
| out_idx | output | N_ELEM*IDX_W | Index tag that travelled with each output key |

## Verification
The bench builds the block with eight lanes, 16-bit keys and 3-bit indices. The index width lets every lane carry a tag equal to its own input position. An ordered output then reveals any loss of stability or any tag that parted from its key. The 16-bit key width makes the all-ones key and keys with the top bit set easy to reach. It also gives a narrow random range that produces many equal keys.

// File: rtl/sortnet_pkg.sv
package sortnet_pkg;

   // Layer parity: even layers pair (0,1),(2,3)...; odd layers pair (1,2),(3,4)...
   function automatic bit layer_is_odd(input int layer);
      return (layer % 2) != 0;
   endfunction

   // Number of compare-exchange cells in a layer of the given parity.
   function automatic int cells_in_layer(input int lanes, input bit odd);
      return odd ? (lanes - 2) / 2 : lanes / 2;
   endfunction

   // First lane touched by a layer of the given parity.
   function automatic int first_lane(input bit odd);
      return odd ? 1 : 0;
   endfunction

endpackage

// File: rtl/sortnet_cas.sv
module sortnet_cas #(
   parameter int KEY_W = 16,
   parameter int IDX_W = 3
) (
   input  logic [KEY_W-1:0] a_key,
   input  logic [IDX_W-1:0] a_idx,
   input  logic [KEY_W-1:0] b_key,
   input  logic [IDX_W-1:0] b_idx,
   output logic [KEY_W-1:0] lo_key,
   output logic [IDX_W-1:0] lo_idx,
   output logic [KEY_W-1:0] hi_key,
   output logic [IDX_W-1:0] hi_idx
);

   logic exch;

   // Strict compare: equal keys stay put, which keeps the sort stable.
   always_comb begin
      exch   = a_key > b_key;
      lo_key = exch ? b_key : a_key;
      lo_idx = exch ? b_idx : a_idx;
      hi_key = exch ? a_key : b_key;
      hi_idx = exch ? a_idx : b_idx;
   end

endmodule

// File: rtl/sortnet_layer.sv
module sortnet_layer
   import sortnet_pkg::*;
#(
   parameter int N_ELEM = 8,
   parameter int KEY_W  = 16,
   parameter int IDX_W  = 3,
   parameter bit ODD    = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    v_i,
   input  logic [N_ELEM*KEY_W-1:0] key_i,
   input  logic [N_ELEM*IDX_W-1:0] idx_i,
   output logic                    v_o,
   output logic [N_ELEM*KEY_W-1:0] key_o,
   output logic [N_ELEM*IDX_W-1:0] idx_o
);

   localparam int NCELL = cells_in_layer(N_ELEM, ODD);
   localparam int BASE  = first_lane(ODD);

   logic [KEY_W-1:0] in_k  [N_ELEM];
   logic [IDX_W-1:0] in_x  [N_ELEM];
   logic [KEY_W-1:0] nxt_k [N_ELEM];
   logic [IDX_W-1:0] nxt_x [N_ELEM];
   logic [KEY_W-1:0] q_k   [N_ELEM];
   logic [IDX_W-1:0] q_x   [N_ELEM];
   logic             v_q;

   for (genvar j = 0; j < N_ELEM; j++) begin : g_unpack
      assign in_k[j] = key_i[j*KEY_W +: KEY_W];
      assign in_x[j] = idx_i[j*IDX_W +: IDX_W];
   end

   for (genvar p = 0; p < NCELL; p++) begin : g_cell
      localparam int LO = BASE + 2*p;
      localparam int HI = LO + 1;

      sortnet_cas #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_cas (
         .a_key (in_k[LO]),
         .a_idx (in_x[LO]),
         .b_key (in_k[HI]),
         .b_idx (in_x[HI]),
         .lo_key(nxt_k[LO]),
         .lo_idx(nxt_x[LO]),
         .hi_key(nxt_k[HI]),
         .hi_idx(nxt_x[HI])
      );

      // R1: smaller key lands on the lower lane
      a_r1_min_low: assert property (@(posedge clk) disable iff (!rst_n)
         v_i |-> (nxt_k[LO] <= nxt_k[HI]));

      // R4: the cell either passes or exchanges whole pairs
      a_r4_pair_kept: assert property (@(posedge clk) disable iff (!rst_n)
         v_i |-> ((nxt_k[LO] == in_k[LO] && nxt_x[LO] == in_x[LO] &&
                   nxt_k[HI] == in_k[HI] && nxt_x[HI] == in_x[HI]) ||
                  (nxt_k[LO] == in_k[HI] && nxt_x[LO] == in_x[HI] &&
                   nxt_k[HI] == in_k[LO] && nxt_x[HI] == in_x[LO])));

      // R7: equal keys are never exchanged
      a_r7_equal_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (v_i && in_k[LO] == in_k[HI]) |-> (nxt_x[LO] == in_x[LO]));
   end

   if (ODD) begin : g_edges
      assign nxt_k[0]        = in_k[0];
      assign nxt_x[0]        = in_x[0];
      assign nxt_k[N_ELEM-1] = in_k[N_ELEM-1];
      assign nxt_x[N_ELEM-1] = in_x[N_ELEM-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_i;
   end

   // Data registers carry no reset; they only load on a valid set.
   always_ff @(posedge clk) begin
      if (v_i) begin
         for (int j = 0; j < N_ELEM; j++) begin
            q_k[j] <= nxt_k[j];
            q_x[j] <= nxt_x[j];
         end
      end
   end

   assign v_o = v_q;
   for (genvar j = 0; j < N_ELEM; j++) begin : g_pack
      assign key_o[j*KEY_W +: KEY_W] = q_k[j];
      assign idx_o[j*IDX_W +: IDX_W] = q_x[j];
   end

endmodule

// File: rtl/sortnet_top.sv
module sortnet_top
   import sortnet_pkg::*;
#(
   parameter int N_ELEM     = 8,
   parameter int KEY_W      = 16,
   parameter int IDX_W      = 3,
   parameter int NUM_LAYERS = N_ELEM
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [N_ELEM*KEY_W-1:0] in_key,
   input  logic [N_ELEM*IDX_W-1:0] in_idx,
   output logic                    out_valid,
   output logic [N_ELEM*KEY_W-1:0] out_key,
   output logic [N_ELEM*IDX_W-1:0] out_idx
);

   localparam int CNT_W = $clog2(NUM_LAYERS + 1) + 1;

   if (N_ELEM < 2 || (N_ELEM % 2) != 0) begin : g_chk_lanes
      $error("sortnet_top: N_ELEM must be even and at least 2");
   end
   if (NUM_LAYERS < N_ELEM) begin : g_chk_layers
      $error("sortnet_top: NUM_LAYERS must be at least N_ELEM to guarantee order");
   end
   if (KEY_W < 1 || IDX_W < 1) begin : g_chk_width
      $error("sortnet_top: KEY_W and IDX_W must be positive");
   end

   logic                    st_v [NUM_LAYERS+1];
   logic [N_ELEM*KEY_W-1:0] st_k [NUM_LAYERS+1];
   logic [N_ELEM*IDX_W-1:0] st_x [NUM_LAYERS+1];

   assign st_v[0] = in_valid;
   assign st_k[0] = in_key;
   assign st_x[0] = in_idx;

   for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
      sortnet_layer #(
         .N_ELEM(N_ELEM),
         .KEY_W (KEY_W),
         .IDX_W (IDX_W),
         .ODD   (layer_is_odd(l))
      ) u_layer (
         .clk  (clk),
         .rst_n(rst_n),
         .v_i  (st_v[l]),
         .key_i(st_k[l]),
         .idx_i(st_x[l]),
         .v_o  (st_v[l+1]),
         .key_o(st_k[l+1]),
         .idx_o(st_x[l+1])
      );
   end

   assign out_valid = st_v[NUM_LAYERS];
   assign out_key   = st_k[NUM_LAYERS];
   assign out_idx   = st_x[NUM_LAYERS];

   // Checking logic: output order and warm-up window
   logic             out_ordered;
   logic [CNT_W-1:0] warm_cnt;

   always_comb begin
      out_ordered = 1'b1;
      for (int j = 0; j < N_ELEM-1; j++) begin
         if (out_key[j*KEY_W +: KEY_W] > out_key[(j+1)*KEY_W +: KEY_W])
            out_ordered = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     warm_cnt <= '0;
      else if (warm_cnt < NUM_LAYERS) warm_cnt <= warm_cnt + 1'b1;
   end

   // R2: every valid output set is ascending
   a_r2_sorted_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_ordered);

   // R3/R6: nothing valid before a set could have crossed every layer
   a_r3_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (warm_cnt >= CNT_W'(NUM_LAYERS)));

endmodule

// File: tb/tb_sortnet_top.sv
module tb_sortnet_top;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 8;
   localparam int KW  = 16;
   localparam int IW  = 3;
   localparam int LAT = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [N*KW-1:0]   in_key = '0;
   logic [N*IW-1:0]   in_idx = '0;
   logic              out_valid;
   logic [N*KW-1:0]   out_key;
   logic [N*IW-1:0]   out_idx;

   sortnet_top #(.N_ELEM(N), .KEY_W(KW), .IDX_W(IW), .NUM_LAYERS(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
      .in_idx(in_idx), .out_valid(out_valid), .out_key(out_key), .out_idx(out_idx)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic          exp_v [LAT];
   logic [KW-1:0] exp_k [LAT][N];
   logic [IW-1:0] exp_x [LAT][N];
   int            slot = 0;
   logic [KW-1:0] stim [N];

   task automatic compare_slot();
      checks++;
      if (out_valid !== exp_v[slot]) begin
         fails++;
         $display("FAIL R3/R5/R9 out_valid actual=%0b expected=%0b", out_valid, exp_v[slot]);
      end
      if (exp_v[slot] && out_valid) begin
         for (int j = 0; j < N; j++) begin
            checks++;
            if (out_key[j*KW +: KW] !== exp_k[slot][j]) begin
               fails++;
               $display("FAIL R1/R2/R8 lane %0d key actual=%0h expected=%0h",
                        j, out_key[j*KW +: KW], exp_k[slot][j]);
            end
            checks++;
            if (out_idx[j*IW +: IW] !== exp_x[slot][j]) begin
               fails++;
               $display("FAIL R4/R7 lane %0d index actual=%0d expected=%0d",
                        j, out_idx[j*IW +: IW], exp_x[slot][j]);
            end
         end
      end
   endtask

   // One cycle: check what is due, then present a new set (or bubble).
   task automatic step(input bit v);
      logic [KW-1:0] k [N];
      logic [IW-1:0] x [N];
      logic [KW-1:0] tk;
      logic [IW-1:0] tx;
      @(negedge clk);
      compare_slot();
      for (int j = 0; j < N; j++) begin
         k[j] = stim[j];
         x[j] = IW'(j);
      end
      // stable insertion sort with strict compare
      for (int a = 1; a < N; a++) begin
         for (int b = a; b > 0; b--) begin
            if (k[b-1] > k[b]) begin
               tk = k[b-1]; k[b-1] = k[b]; k[b] = tk;
               tx = x[b-1]; x[b-1] = x[b]; x[b] = tx;
            end
         end
      end
      exp_v[slot] = v;
      for (int j = 0; j < N; j++) begin
         exp_k[slot][j] = k[j];
         exp_x[slot][j] = x[j];
         in_key[j*KW +: KW] = stim[j];
         in_idx[j*IW +: IW] = IW'(j);
      end
      in_valid = v;
      slot = (slot + 1) % LAT;
   endtask

   initial begin
      void'($urandom(32'h0005_EED1));
      for (int s = 0; s < LAT; s++) exp_v[s] = 1'b0;
      // R6: valid held high during reset must not reach the output
      in_valid = 1'b1;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         checks++;
         if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R6 out_valid in reset actual=%0b expected=0", out_valid);
         end
      end
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      // R6: empty pipeline after reset (bubbles checked via slots)
      for (int j = 0; j < N; j++) stim[j] = 16'h1111;
      for (int c = 0; c < 4; c++) step(1'b0);

      // Directed: reverse order (R1, R2)
      for (int j = 0; j < N; j++) stim[j] = KW'(100 - 10*j);
      step(1'b1);
      // Directed: already ordered
      for (int j = 0; j < N; j++) stim[j] = KW'(3*j + 1);
      step(1'b1);
      // Directed: all equal keys, R7 stability
      for (int j = 0; j < N; j++) stim[j] = 16'h0042;
      step(1'b1);
      // Directed: R8 unsigned, top bit set and all-ones
      stim = '{16'hFFFF, 16'h0000, 16'h8000, 16'h7FFF, 16'h0001, 16'h8001, 16'hFFFE, 16'h0000};
      step(1'b1);
      // Directed: duplicate pairs scattered, R7
      stim = '{16'd5, 16'd2, 16'd5, 16'd2, 16'd9, 16'd2, 16'd5, 16'd9};
      step(1'b1);
      // Directed: R9, data with valid low is a bubble
      for (int j = 0; j < N; j++) stim[j] = KW'(j ^ 7);
      step(1'b0);
      step(1'b0);
      // Random stream, back-to-back and with bubbles (R5)
      for (int c = 0; c < 400; c++) begin
         bit narrow;
         narrow = ($urandom % 2) == 0;
         for (int j = 0; j < N; j++)
            stim[j] = narrow ? KW'($urandom % 4) : KW'($urandom);
         step(($urandom % 4) != 0);
      end
      // Drain
      for (int c = 0; c < LAT + 4; c++) step(1'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule